// File: doc/BRIEF.md
# Chained Integer Multiply-Add Unit

This block holds a multiplier stage and an adder pipeline that work side by side, driven by a single instruction. An instruction names only two source operands and one destination index. A 6-bit path code fills in the other operands. Each of the four arithmetic inputs is taken from a source operand, from one of two constant registers (`k_real`, `k_imag`), from the transfer register `xfer`, or, for the second adder input, from the multiplier's product. Software loads the three internal registers through their own write enables, which share one load data bus.

The unit is pipelined in the style of a vector inner loop. Every legal issue pushes a new operation in. The destination index given with that issue receives the result of the operation issued a fixed number of issues earlier. That distance is 6 issues in single mode and 5 in double mode. The first issues after reset or after a mode change only prime the pipeline. After that, every issue completes one multiply and one add. Two path codes are illegal. Such an issue raises an error pulse and is dropped without touching the pipeline.

A two-state controller tracks the priming. State `ST_PRIME` counts legal issues. On the last priming issue (transition `PRIMED`) it moves to `ST_RUN`, where each legal issue produces a write. A change of the mode input (transition `MODE_SWITCH`) returns it from either state to `ST_PRIME` with the count restarted. Reset (transition `RESET`) puts it in `ST_PRIME` with the count at zero and single mode recorded.

Top module: `cma_unit`

## Requirements
- R1: Multiplier inputs are chosen by the path code. Bits [1:0] pick the first input: 0 = k_real, 1 = k_imag, 2 = src1, 3 = xfer. Bit [2] picks the second input: 0 = src1, 1 = src2.
- R2: Adder inputs are chosen by the path code. Bits [4:3] pick the first input: 0 = src2, 1 = xfer, 2 = k_real, 3 = k_imag. Bit [5] picks the second input: 0 = the product of the same operation, 1 = xfer.
- R3: Path codes 0x2B and 0x2F are illegal. Issuing one sets `err_o` for exactly the following cycle and produces no write. It neither advances the pipeline nor counts as a priming issue, so later results are as if the issue never happened.
- R4: Path code 0 computes k_real*src1 + src2.
- R5: In single mode (`dbl_i` = 0), the first 6 legal issues after reset or after a mode change produce no write. Every later legal issue writes the result of the legal issue made 6 legal issues before it.
- R6: In double mode (`dbl_i` = 1), the priming count is 5, and the written result is that of the legal issue made 5 legal issues before it.
- R7: A write appears one cycle after the issue that causes it, as a one-cycle `wr_en_o` pulse. `wr_idx_o` carries that issue's `dst_i`.
- R8: A load of k_real, k_imag or xfer takes effect on the next issue. An issue in the same cycle as the load uses the old value.
- R9: Products and sums are kept modulo 2^W.
- R10: A change of `dbl_i` in a cycle without an issue restarts the priming count. The pipeline holds no valid result until the new count is reached.
- R11: After reset, `wr_en_o` and `err_o` are low.
- R12: A cycle without an issue produces neither a write nor an error in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction strobe |
| path_i | input | 6 | Path code |
| src1_i | input | W | Source operand 1 |
| src2_i | input | W | Source operand 2 |
| dst_i | input | IDXW | Destination index of this issue |
| dbl_i | input | 1 | Mode: 0 single (6 priming issues), 1 double (5) |
| kr_we_i | input | 1 | Load k_real from ld_data_i |
| ki_we_i | input | 1 | Load k_imag from ld_data_i |
| t_we_i | input | 1 | Load xfer from ld_data_i |
| ld_data_i | input | W | Load data for the internal registers |
| wr_en_o | output | 1 | Result write strobe |
| wr_idx_o | output | IDXW | Result destination index |
| wr_data_o | output | W | Result data |
| err_o | output | 1 | Illegal path code seen on the previous cycle |

## Verification
The bench builds the unit with W = 8 and IDXW = 5, and keeps the priming counts at 6 and 5. With 8-bit operands most random products overflow, so the modulo rule of R9 is exercised on nearly every multiply rather than only at hand-picked values. The narrow width also makes repeated operand values common, which lets the model show that a load in the same cycle as an issue does not leak into that issue. The run switches modes several times with a pipeline that is still full. Each switch shows that stale entries are never written before the new priming count is reached.

// File: rtl/cma_pkg.sv
package cma_pkg;

    typedef enum logic [1:0] {MA_KR = 2'd0, MA_KI = 2'd1, MA_S1 = 2'd2, MA_XF = 2'd3} mul_a_e;
    typedef enum logic [1:0] {AA_S2 = 2'd0, AA_XF = 2'd1, AA_KR = 2'd2, AA_KI = 2'd3} add_a_e;
    typedef enum logic [0:0] {ST_PRIME = 1'b0, ST_RUN = 1'b1} ctl_state_e;

    // Both adder inputs and the first multiplier input all tied to the transfer register
    function automatic logic path_illegal(input logic [5:0] code);
        return (code[1:0] == MA_XF) && (code[4:3] == AA_XF) && code[5];
    endfunction

endpackage

// File: rtl/cma_route.sv
module cma_route
    import cma_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [5:0]   path,
    input  logic [W-1:0] src1,
    input  logic [W-1:0] src2,
    input  logic [W-1:0] k_real,
    input  logic [W-1:0] k_imag,
    input  logic [W-1:0] xfer,
    output logic [W-1:0] mul_a,
    output logic [W-1:0] mul_b,
    output logic [W-1:0] add_a,
    output logic         use_xfer,
    output logic         legal
);
    mul_a_e ma_sel;
    add_a_e aa_sel;

    assign ma_sel   = mul_a_e'(path[1:0]);
    assign aa_sel   = add_a_e'(path[4:3]);
    assign use_xfer = path[5];
    assign legal    = !path_illegal(path);
    assign mul_b    = path[2] ? src2 : src1;

    always_comb begin
        unique case (ma_sel)
            MA_KR: mul_a = k_real;
            MA_KI: mul_a = k_imag;
            MA_S1: mul_a = src1;
            MA_XF: mul_a = xfer;
        endcase
        unique case (aa_sel)
            AA_S2: add_a = src2;
            AA_XF: add_a = xfer;
            AA_KR: add_a = k_real;
            AA_KI: add_a = k_imag;
        endcase
    end

endmodule

// File: rtl/cma_pipe.sv
module cma_pipe #(
    parameter int W     = 16,
    parameter int DEPTH = 6,
    parameter int TAP_S = 5,
    parameter int TAP_D = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] mul_a,
    input  logic [W-1:0] mul_b,
    input  logic [W-1:0] add_a,
    input  logic         use_xfer,
    input  logic [W-1:0] xfer,
    output logic [W-1:0] tap_s,
    output logic [W-1:0] tap_d
);
    // Multiplier stage
    logic [W-1:0] prod_q, addend_q, xfer_q;
    logic         use_xfer_q;
    // Adder pipeline: sum_q[1] is the adder output, later entries shift it along
    logic [W-1:0] sum_q [1:DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q     <= '0;
            addend_q   <= '0;
            xfer_q     <= '0;
            use_xfer_q <= 1'b0;
            sum_q[1]   <= '0;
        end else if (adv) begin
            prod_q     <= mul_a * mul_b;
            addend_q   <= add_a;
            xfer_q     <= xfer;
            use_xfer_q <= use_xfer;
            sum_q[1]   <= addend_q + (use_xfer_q ? xfer_q : prod_q);
        end
    end

    for (genvar k = 2; k < DEPTH; k++) begin : g_shift
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sum_q[k] <= '0;
            else if (adv) sum_q[k] <= sum_q[k-1];
        end
    end

    assign tap_s = sum_q[TAP_S];
    assign tap_d = sum_q[TAP_D];

endmodule

// File: rtl/cma_seq.sv
module cma_seq
    import cma_pkg::*;
#(
    parameter int PRIME_SGL = 6,
    parameter int PRIME_DBL = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_ok,
    input  logic dbl,
    output logic fire
);
    localparam int CW = $clog2(PRIME_SGL + 1);
    localparam logic [CW-1:0] LAST_S = CW'(PRIME_SGL - 1);
    localparam logic [CW-1:0] LAST_D = CW'(PRIME_DBL - 1);

    ctl_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d, last;
    logic          dbl_q, chg;

    assign last = dbl ? LAST_D : LAST_S;
    assign chg  = dbl != dbl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
            dbl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dbl_q   <= dbl;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (chg) begin
            state_d = ST_PRIME;
            cnt_d   = issue_ok ? CW'(1) : '0;
        end else begin
            unique case (state_q)
                ST_PRIME: if (issue_ok) begin
                    if (cnt_q == last) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                ST_RUN: fire = issue_ok;
            endcase
        end
    end

    AST_PRIME_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_S) else $error("priming count out of range"); // R5
    AST_RUN_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |-> cnt_q == '0) else $error("count left nonzero in run"); // R6
    AST_SWITCH_REPRIME: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl != dbl_q) |=> state_q == ST_PRIME) else $error("mode switch kept run state"); // R10

endmodule

// File: rtl/cma_unit.sv
module cma_unit
    import cma_pkg::*;
#(
    parameter int W         = 16,
    parameter int IDXW      = 5,
    parameter int PRIME_SGL = 6,
    parameter int PRIME_DBL = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_i,
    input  logic [5:0]      path_i,
    input  logic [W-1:0]    src1_i,
    input  logic [W-1:0]    src2_i,
    input  logic [IDXW-1:0] dst_i,
    input  logic            dbl_i,
    input  logic            kr_we_i,
    input  logic            ki_we_i,
    input  logic            t_we_i,
    input  logic [W-1:0]    ld_data_i,
    output logic            wr_en_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [W-1:0]    wr_data_o,
    output logic            err_o
);
    localparam int DEPTH = (PRIME_SGL > PRIME_DBL) ? PRIME_SGL : PRIME_DBL;

    logic [W-1:0] k_real_q, k_imag_q, xfer_q;
    logic [W-1:0] mul_a, mul_b, add_a, tap_s, tap_d;
    logic         use_xfer, legal, issue_ok, fire;

    assign issue_ok = issue_i && legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_real_q <= '0;
            k_imag_q <= '0;
            xfer_q   <= '0;
        end else begin
            if (kr_we_i) k_real_q <= ld_data_i;
            if (ki_we_i) k_imag_q <= ld_data_i;
            if (t_we_i)  xfer_q   <= ld_data_i;
        end
    end

    cma_route #(.W(W)) u_route (
        .path(path_i), .src1(src1_i), .src2(src2_i),
        .k_real(k_real_q), .k_imag(k_imag_q), .xfer(xfer_q),
        .mul_a(mul_a), .mul_b(mul_b), .add_a(add_a),
        .use_xfer(use_xfer), .legal(legal)
    );

    cma_pipe #(.W(W), .DEPTH(DEPTH), .TAP_S(PRIME_SGL - 1), .TAP_D(PRIME_DBL - 1)) u_pipe (
        .clk(clk), .rst_n(rst_n), .adv(issue_ok),
        .mul_a(mul_a), .mul_b(mul_b), .add_a(add_a),
        .use_xfer(use_xfer), .xfer(xfer_q),
        .tap_s(tap_s), .tap_d(tap_d)
    );

    cma_seq #(.PRIME_SGL(PRIME_SGL), .PRIME_DBL(PRIME_DBL)) u_seq (
        .clk(clk), .rst_n(rst_n), .issue_ok(issue_ok), .dbl(dbl_i), .fire(fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
            err_o     <= 1'b0;
        end else begin
            wr_en_o <= fire;
            err_o   <= issue_i && !legal;
            if (fire) begin
                wr_idx_o  <= dst_i;
                wr_data_o <= dbl_i ? tap_d : tap_s;
            end
        end
    end

    AST_ERR_FROM_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(issue_i && (path_i == 6'h2B || path_i == 6'h2F))) else $error("spurious error"); // R3
    AST_BAD_CODE_HOLDS_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (path_i == 6'h2B || path_i == 6'h2F)) |=> $stable(tap_s) && $stable(tap_d) && !wr_en_o)
        else $error("illegal issue moved the pipeline"); // R3
    AST_WRITE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(issue_i)) else $error("write without issue"); // R12
    AST_WRITE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> wr_idx_o == $past(dst_i)) else $error("wrong write index"); // R7
    AST_ERR_EXCLUDES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && wr_en_o)) else $error("error and write together"); // R3

endmodule

// File: tb/sim_cma_unit.sv
`timescale 1ns/1ps
module sim_cma_unit;
    localparam int W = 8;
    localparam int IDXW = 5;
    localparam int NH = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_i = 1'b0;
    logic [5:0] path_i = '0;
    logic [W-1:0] src1_i = '0, src2_i = '0, ld_data_i = '0;
    logic [IDXW-1:0] dst_i = '0;
    logic dbl_i = 1'b0, kr_we_i = 1'b0, ki_we_i = 1'b0, t_we_i = 1'b0;
    logic wr_en_o, err_o;
    logic [IDXW-1:0] wr_idx_o;
    logic [W-1:0] wr_data_o;

    always #10 clk = ~clk;

    cma_unit #(.W(W), .IDXW(IDXW), .PRIME_SGL(6), .PRIME_DBL(5)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .path_i(path_i),
        .src1_i(src1_i), .src2_i(src2_i), .dst_i(dst_i), .dbl_i(dbl_i),
        .kr_we_i(kr_we_i), .ki_we_i(ki_we_i), .t_we_i(t_we_i), .ld_data_i(ld_data_i),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .err_o(err_o)
    );

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] m_kr = '0, m_ki = '0, m_t = '0;
    logic [W-1:0] hist [0:NH-1];
    int gi = 0, seg = 0;
    logic m_dbl = 1'b0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R1, R2, R9: independent operand selection and modulo arithmetic
    function automatic logic [W-1:0] model_res(input logic [5:0] c, input logic [W-1:0] s1,
                                               input logic [W-1:0] s2);
        logic [W-1:0] a, b, x, p;
        case (c[1:0])
            2'd0: a = m_kr;
            2'd1: a = m_ki;
            2'd2: a = s1;
            default: a = m_t;
        endcase
        b = c[2] ? s2 : s1;
        case (c[4:3])
            2'd0: x = s2;
            2'd1: x = m_t;
            2'd2: x = m_kr;
            default: x = m_ki;
        endcase
        p = W'((a * b) % (1 << W));
        return W'((x + (c[5] ? m_t : p)) % (1 << W));
    endfunction

    function automatic bit bad_code(input logic [5:0] c);
        return c == 6'h2B || c == 6'h2F;
    endfunction

    // Drive one cycle at the negedge, check the registered outputs at the next negedge
    task automatic step(input bit iss, input logic [5:0] c, input logic [W-1:0] s1,
                        input logic [W-1:0] s2, input logic [IDXW-1:0] d,
                        input bit lkr, input bit lki, input bit lt, input logic [W-1:0] ld);
        int dep, k;
        bit exp_wr, exp_err;
        logic [W-1:0] exp_d, r;
        issue_i = iss; path_i = c; src1_i = s1; src2_i = s2; dst_i = d;
        kr_we_i = lkr; ki_we_i = lki; t_we_i = lt; ld_data_i = ld;
        dep = m_dbl ? 5 : 6;
        exp_wr = 0; exp_err = 0; exp_d = '0;
        if (iss && bad_code(c)) exp_err = 1;
        else if (iss) begin
            r = model_res(c, s1, s2);      // R8: old register values
            k = gi - seg;
            if (k >= dep) begin
                exp_wr = 1;
                exp_d = hist[(gi - dep) % NH];
            end
            hist[gi % NH] = r;
            gi++;
        end
        if (lkr) m_kr = ld;
        if (lki) m_ki = ld;
        if (lt)  m_t  = ld;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0; kr_we_i = 1'b0; ki_we_i = 1'b0; t_we_i = 1'b0;
        if (!iss) begin
            chk(!wr_en_o && !err_o, "R12 idle cycle quiet", int'(wr_en_o) + int'(err_o), 0);
        end else if (exp_err) begin
            chk(err_o && !wr_en_o, "R3 illegal code flagged, no write", int'(err_o), 1);
        end else begin
            chk(wr_en_o == exp_wr, m_dbl ? "R6 write timing" : "R5 write timing",
                int'(wr_en_o), int'(exp_wr));
            chk(!err_o, "R3 no error on legal code", int'(err_o), 0);
            if (exp_wr && wr_en_o) begin
                chk(wr_data_o == exp_d, "R1 R2 R9 result data", int'(wr_data_o), int'(exp_d));
                chk(wr_idx_o == d, "R7 write index", int'(wr_idx_o), int'(d));
            end
        end
    endtask

    task automatic set_mode(input bit dbl);
        dbl_i = dbl;
        m_dbl = dbl;
        seg = gi;           // R10: priming restarts
        step(0, '0, '0, '0, '0, 0, 0, 0, '0);
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [5:0] c;
            c = 6'($urandom);
            if ($urandom_range(0, 19) == 0) c = ($urandom_range(0, 1) != 0) ? 6'h2B : 6'h2F;
            step($urandom_range(0, 3) != 0, c, W'($urandom), W'($urandom), IDXW'($urandom),
                 $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
                 $urandom_range(0, 5) == 0, W'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!wr_en_o && !err_o, "R11 reset outputs low", int'(wr_en_o) + int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_en_o && !err_o, "R11 outputs low after release", int'(wr_en_o) + int'(err_o), 0);

        // R4: k_real*src1+src2; R8: load with same-cycle issue uses old value
        step(0, '0, '0, '0, '0, 1, 0, 0, 8'd3);
        step(1, 6'h00, 8'd5, 8'd7, 5'd1, 1, 0, 0, 8'd100);   // uses k_real=3 -> 22
        for (int i = 0; i < 5; i++) step(1, 6'h00, 8'd1, 8'd0, 5'(i + 2), 0, 0, 0, '0);
        step(1, 6'h00, 8'd0, 8'd0, 5'd9, 0, 0, 0, '0);       // writes 22
        chk(wr_data_o == 8'd22, "R4 R8 path 0 result with same-cycle load", int'(wr_data_o), 22);
        // R9: wrap-around
        step(1, 6'h02, 8'd200, 8'd0, 5'd3, 0, 0, 0, '0);     // 200*200 + 0
        // R3: illegal codes in the middle of a primed stream
        step(1, 6'h2B, 8'd9, 8'd9, 5'd4, 0, 0, 0, '0);
        step(1, 6'h2F, 8'd9, 8'd9, 5'd4, 0, 0, 0, '0);
        rand_run(600);

        set_mode(1);        // R6, R10
        rand_run(500);
        set_mode(0);
        rand_run(400);
        set_mode(1);
        for (int i = 0; i < 12; i++) step(1, 6'h2B, 8'd1, 8'd1, '0, 0, 0, 0, '0); // R3 no priming credit
        rand_run(300);
        set_mode(0);
        for (int i = 0; i < 7; i++) step(1, 6'h20, 8'd2, 8'd2, 5'(i), 0, 0, 1, 8'(i)); // R8 xfer chain
        rand_run(300);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule